// File: doc/BRIEF.md
# Three-Phase Clamping Offset Selector

This block serves a carrier-based five-level modulator. Each phase control value lies on a scale from 0 to 4, where the integers are the carrier levels. Once per carrier period, a sample strobe presents three control values and three signed load-current samples. The block works out one common offset. Added to all three control values, that offset moves one chosen phase exactly onto a carrier level, so that the phase makes no commutation during the period. Line-to-line voltages are unchanged, because the same offset goes to every phase.

The clamped phase is normally the phase that carries the most current. It is clamped downward if its fractional position inside its carrier band is the smallest of the three, and upward if it is the largest. If that fraction is the middle one, the decision passes to the phase with the second-largest current. That phase's fraction is then certain to be an extreme. The whole selection uses comparisons, one subtraction and one-hot rank flags, so it fits a two-stage pipeline.

The outputs are the three shifted control values and a one-hot flag naming the clamped phase. A single-cycle valid pulse marks each result.

Top module: `clamp_offset_sel`

## Requirements
- R1: A control value is unsigned fixed point with FRAC_W fraction bits, and an input above 4.0 is treated as exactly 4.0. The base level is the integer part of the value, except that 4.0 gives level 3. The fraction is the value minus its base level, from 0 to 1.0 inclusive. A current magnitude is the absolute value of the two's-complement sample, and the most negative code has the largest magnitude.
- R2: Currents and fractions are each ranked into largest, middle and smallest. On equal values, phase a ranks above b and b ranks above c, so the largest flag goes to the earliest of the tied phases and the smallest flag goes to the latest.
- R3: If the deciding phase has the smallest fraction, the offset is minus that fraction. Its shifted value then lands on its base level.
- R4: If the deciding phase has the largest fraction, the offset is 1.0 minus that fraction. Its shifted value then lands on its base level plus one.
- R5: The deciding phase is the largest-current phase, unless that phase has the middle fraction. In that case the middle-current phase decides.
- R6: Each shifted output equals its (limited) input plus the one common offset, held within 0 to 4.0.
- R7: The clamp flag clamp_o is one-hot, with bit 0 for phase a, bit 1 for b and bit 2 for c. It names the deciding phase, and that phase's output has a zero fraction.
- R8: Outputs and clamp_o update only two clock edges after the edge that captures sample_i high. valid_o is high for exactly that one cycle. With no strobe, all outputs hold their values.
- R9: During reset, all outputs, clamp_o and valid_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe, one per carrier period |
| ctrl_a_i | input | FRAC_W+3 | Phase a control value |
| ctrl_b_i | input | FRAC_W+3 | Phase b control value |
| ctrl_c_i | input | FRAC_W+3 | Phase c control value |
| cur_a_i | input | CUR_W | Phase a current sample, signed |
| cur_b_i | input | CUR_W | Phase b current sample, signed |
| cur_c_i | input | CUR_W | Phase c current sample, signed |
| valid_o | output | 1 | Result strobe |
| shift_a_o | output | FRAC_W+3 | Phase a shifted control value |
| shift_b_o | output | FRAC_W+3 | Phase b shifted control value |
| shift_c_o | output | FRAC_W+3 | Phase c shifted control value |
| clamp_o | output | 3 | One-hot clamped-phase flag |

## Verification
The assertions check on every cycle that each result comes two edges after its strobe and that outputs hold between strobes. They also check that the clamp flag is one-hot, that the flagged phase sits on an integer level, that outputs stay within 0 to 4.0, and that for in-range inputs all three phases move by the same amount. Which phase is chosen, and whether it moves up or down, depends on the joint ranking of currents and fractions. Only the bench's scenarios can show this: the fallback to the middle-current phase, tie ordering, the 4.0 edge, over-range inputs and the most negative current code.

// File: rtl/clamp_sel_pkg.sv
package clamp_sel_pkg;
  localparam int NPH   = 3;
  localparam int INT_W = 3;
  typedef logic [NPH-1:0] ph_oh_t;
endpackage

// File: rtl/csel_prep.sv
module csel_prep #(
  parameter int FRAC_W = 8,
  parameter int CUR_W  = 12,
  localparam int CTRL_W = clamp_sel_pkg::INT_W + FRAC_W,
  localparam int E_W    = FRAC_W + 1
) (
  input  logic [CTRL_W-1:0]       ctrl_i,
  input  logic signed [CUR_W-1:0] cur_i,
  output logic [CTRL_W-1:0]       ctrl_lim_o,
  output logic [E_W-1:0]          err_o,
  output logic [CUR_W-1:0]        mag_o
);
  localparam logic [CTRL_W-1:0] FULL = CTRL_W'(4) << FRAC_W;

  logic [clamp_sel_pkg::INT_W-1:0] int_part;
  logic [clamp_sel_pkg::INT_W-1:0] lvl;
  logic [CTRL_W-1:0]               base;

  always_comb begin
    ctrl_lim_o = (ctrl_i > FULL) ? FULL : ctrl_i;
    int_part   = ctrl_lim_o[CTRL_W-1:FRAC_W];
    lvl        = (int_part >= clamp_sel_pkg::INT_W'(4)) ? clamp_sel_pkg::INT_W'(3) : int_part;
    base       = {lvl, {FRAC_W{1'b0}}};
    err_o      = E_W'(ctrl_lim_o - base);
    // magnitude as unsigned so the most negative code still fits
    mag_o      = cur_i[CUR_W-1] ? (~cur_i + CUR_W'(1)) : cur_i;
  end
endmodule

// File: rtl/csel_rank3.sv
module csel_rank3 #(
  parameter int W = 8
) (
  input  logic [2:0][W-1:0] val_i,
  output logic [2:0]        max_o,
  output logic [2:0]        med_o,
  output logic [2:0]        min_o
);
  logic [2:0][2:0] above;  // above[x][y]: x ranks over y

  always_comb begin
    for (int x = 0; x < 3; x++) begin
      for (int y = 0; y < 3; y++) begin
        if (x == y)     above[x][y] = 1'b0;
        else if (x < y) above[x][y] = (val_i[x] >= val_i[y]);
        else            above[x][y] = (val_i[x] >  val_i[y]);
      end
    end
    for (int x = 0; x < 3; x++) begin
      max_o[x] = 1'b1;
      min_o[x] = 1'b1;
      for (int y = 0; y < 3; y++) begin
        if (y != x) begin
          max_o[x] = max_o[x] & above[x][y];
          min_o[x] = min_o[x] & above[y][x];
        end
      end
    end
    med_o = ~(max_o | min_o);
  end
endmodule

// File: rtl/csel_offset.sv
module csel_offset #(
  parameter int FRAC_W = 8,
  localparam int E_W   = FRAC_W + 1,
  localparam int OFF_W = FRAC_W + 2
) (
  input  logic [2:0][E_W-1:0]     err_i,
  input  logic [2:0]              cur_max_i,
  input  logic [2:0]              cur_med_i,
  input  logic [2:0]              err_max_i,
  input  logic [2:0]              err_med_i,
  input  logic [2:0]              err_min_i,
  output logic signed [OFF_W-1:0] off_o,
  output logic [2:0]              lead_o
);
  localparam logic signed [OFF_W-1:0] ONE = OFF_W'(1) << FRAC_W;

  logic [E_W-1:0]          lead_err;
  logic                    use_min;
  logic signed [OFF_W-1:0] err_s;

  always_comb begin
    lead_o   = (|(cur_max_i & err_med_i)) ? cur_med_i : cur_max_i;
    lead_err = '0;
    for (int x = 0; x < 3; x++) begin
      if (lead_o[x]) lead_err = lead_err | err_i[x];
    end
    use_min = |(lead_o & err_min_i);
    err_s   = $signed({1'b0, lead_err});
    off_o   = use_min ? -err_s : (ONE - err_s);
  end

  logic unused_ok;
  assign unused_ok = ^err_max_i;
endmodule

// File: rtl/clamp_offset_sel.sv
module clamp_offset_sel #(
  parameter int FRAC_W = 8,
  parameter int CUR_W  = 12,
  localparam int CTRL_W = clamp_sel_pkg::INT_W + FRAC_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sample_i,
  input  logic [CTRL_W-1:0]       ctrl_a_i,
  input  logic [CTRL_W-1:0]       ctrl_b_i,
  input  logic [CTRL_W-1:0]       ctrl_c_i,
  input  logic signed [CUR_W-1:0] cur_a_i,
  input  logic signed [CUR_W-1:0] cur_b_i,
  input  logic signed [CUR_W-1:0] cur_c_i,
  output logic                    valid_o,
  output logic [CTRL_W-1:0]       shift_a_o,
  output logic [CTRL_W-1:0]       shift_b_o,
  output logic [CTRL_W-1:0]       shift_c_o,
  output logic [2:0]              clamp_o
);
  import clamp_sel_pkg::*;

  localparam int E_W   = FRAC_W + 1;
  localparam int OFF_W = FRAC_W + 2;
  localparam int SUM_W = CTRL_W + 2;
  localparam logic signed [SUM_W-1:0] FULL_S = SUM_W'(4) << FRAC_W;

  logic [NPH-1:0][CTRL_W-1:0]       ctrl_in;
  logic [NPH-1:0][CUR_W-1:0]        cur_in;
  logic [NPH-1:0][CTRL_W-1:0]       lim_d, lim_q;
  logic [NPH-1:0][E_W-1:0]          err_d, err_q;
  logic [NPH-1:0][CUR_W-1:0]        mag_d, mag_q;
  logic                             s1_vld;

  assign ctrl_in = {ctrl_c_i, ctrl_b_i, ctrl_a_i};
  assign cur_in  = {cur_c_i, cur_b_i, cur_a_i};

  // stage 1: level, fraction, magnitude per phase
  for (genvar g = 0; g < NPH; g++) begin : g_ph
    csel_prep #(.FRAC_W(FRAC_W), .CUR_W(CUR_W)) u_prep (
      .ctrl_i     (ctrl_in[g]),
      .cur_i      ($signed(cur_in[g])),
      .ctrl_lim_o (lim_d[g]),
      .err_o      (err_d[g]),
      .mag_o      (mag_d[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lim_q  <= '0;
      err_q  <= '0;
      mag_q  <= '0;
      s1_vld <= 1'b0;
    end else begin
      s1_vld <= sample_i;
      if (sample_i) begin
        lim_q <= lim_d;
        err_q <= err_d;
        mag_q <= mag_d;
      end
    end
  end

  // stage 2: rank, select offset, shift and limit
  ph_oh_t cur_max, cur_med, cur_min;
  ph_oh_t err_max, err_med, err_min;
  ph_oh_t lead;
  logic signed [OFF_W-1:0] off;

  csel_rank3 #(.W(CUR_W)) u_rank_cur (
    .val_i (mag_q),
    .max_o (cur_max),
    .med_o (cur_med),
    .min_o (cur_min)
  );

  csel_rank3 #(.W(E_W)) u_rank_err (
    .val_i (err_q),
    .max_o (err_max),
    .med_o (err_med),
    .min_o (err_min)
  );

  csel_offset #(.FRAC_W(FRAC_W)) u_off (
    .err_i     (err_q),
    .cur_max_i (cur_max),
    .cur_med_i (cur_med),
    .err_max_i (err_max),
    .err_med_i (err_med),
    .err_min_i (err_min),
    .off_o     (off),
    .lead_o    (lead)
  );

  logic [NPH-1:0][CTRL_W-1:0] shift_d, shift_q;
  logic signed [SUM_W-1:0]    sum [NPH];

  always_comb begin
    for (int x = 0; x < NPH; x++) begin
      sum[x] = $signed({2'b00, lim_q[x]}) + SUM_W'(off);
      if (sum[x] < 0)           shift_d[x] = '0;
      else if (sum[x] > FULL_S) shift_d[x] = FULL_S[CTRL_W-1:0];
      else                      shift_d[x] = sum[x][CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      clamp_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= s1_vld;
      if (s1_vld) begin
        shift_q <= shift_d;
        clamp_o <= lead;
      end
    end
  end

  assign shift_a_o = shift_q[0];
  assign shift_b_o = shift_q[1];
  assign shift_c_o = shift_q[2];

  logic unused_ok;
  assign unused_ok = ^cur_min;
endmodule

// File: rtl/clamp_offset_sel_chk.sv
module clamp_offset_sel_chk #(
  parameter int FRAC_W = 8,
  parameter int CUR_W  = 12,
  localparam int CTRL_W = clamp_sel_pkg::INT_W + FRAC_W
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    sample_i,
  input logic [CTRL_W-1:0]       ctrl_a_i,
  input logic [CTRL_W-1:0]       ctrl_b_i,
  input logic [CTRL_W-1:0]       ctrl_c_i,
  input logic signed [CUR_W-1:0] cur_a_i,
  input logic signed [CUR_W-1:0] cur_b_i,
  input logic signed [CUR_W-1:0] cur_c_i,
  input logic                    valid_o,
  input logic [CTRL_W-1:0]       shift_a_o,
  input logic [CTRL_W-1:0]       shift_b_o,
  input logic [CTRL_W-1:0]       shift_c_o,
  input logic [2:0]              clamp_o
);
  localparam logic [CTRL_W-1:0] FULL = CTRL_W'(4) << FRAC_W;
  localparam int D_W = CTRL_W + 2;

  logic [CTRL_W-1:0] a1, b1, c1, a2, b2, c2;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {a1, b1, c1, a2, b2, c2} <= '0;
    end else begin
      {a1, b1, c1} <= {ctrl_a_i, ctrl_b_i, ctrl_c_i};
      {a2, b2, c2} <= {a1, b1, c1};
    end
  end

  logic signed [D_W-1:0] dif_a, dif_b, dif_c;
  logic                  in_rng;
  logic [2:0]            frac_nz;
  assign dif_a   = $signed({2'b00, shift_a_o}) - $signed({2'b00, a2});
  assign dif_b   = $signed({2'b00, shift_b_o}) - $signed({2'b00, b2});
  assign dif_c   = $signed({2'b00, shift_c_o}) - $signed({2'b00, c2});
  assign in_rng  = (a2 <= FULL) && (b2 <= FULL) && (c2 <= FULL);
  assign frac_nz = {|shift_c_o[FRAC_W-1:0], |shift_b_o[FRAC_W-1:0], |shift_a_o[FRAC_W-1:0]};

  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i |-> ##2 valid_o);
  p_valid_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(sample_i, 2));
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> ($stable(shift_a_o) && $stable(shift_b_o) && $stable(shift_c_o) && $stable(clamp_o)));
  p_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ($countones(clamp_o) == 1));
  p_on_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((clamp_o & frac_nz) == 3'b000));
  p_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_a_o <= FULL) && (shift_b_o <= FULL) && (shift_c_o <= FULL));
  p_common_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && in_rng) |-> ((dif_a == dif_b) && (dif_b == dif_c)));

  logic unused_ok;
  assign unused_ok = ^{cur_a_i, cur_b_i, cur_c_i};
endmodule

bind clamp_offset_sel clamp_offset_sel_chk #(.FRAC_W(FRAC_W), .CUR_W(CUR_W)) u_chk (.*);

// File: tb/sim_clamp_offset_sel.sv
`timescale 1ns/1ps
module sim_clamp_offset_sel;
  localparam int FRAC_W = 8;
  localparam int CUR_W  = 12;
  localparam int CTRL_W = 3 + FRAC_W;

  typedef struct packed {
    logic [CTRL_W-1:0] va, vb, vc;
    logic [CUR_W-1:0]  ia, ib, ic;
    logic [CTRL_W-1:0] oa, ob, oc;
    logic [2:0]        ck;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{11'd288, 11'd160, 11'd832, 12'd300, 12'd200, 12'd100, 11'd256, 11'd128, 11'd800, 3'b001},
    '{11'd480, 11'd160, 11'd600, 12'd300, 12'd10, 12'd20, 11'd512, 11'd192, 11'd632, 3'b001},
    '{11'd300, 11'd160, 11'd600, -12'sd50, 12'd200, -12'sd400, 11'd396, 11'd256, 11'd696, 3'b010},
    '{11'd300, 11'd160, 11'd600, 12'd300, -12'sd10, -12'sd400, 11'd256, 11'd116, 11'd556, 3'b001},
    '{11'd1100, 11'd512, 11'd0, 12'd5, 12'd100, 12'd1, 11'd1024, 11'd512, 11'd0, 3'b001},
    '{11'd320, 11'd320, 11'd320, 12'd10, 12'd10, 12'd10, 11'd512, 11'd512, 11'd512, 3'b001},
    '{11'd288, 11'd160, 11'd832, -12'sd100, 12'd100, 12'd0, 11'd256, 11'd128, 11'd800, 3'b001},
    '{11'd300, 11'd160, 11'd600, 12'd0, 12'h800, 12'd2047, 11'd396, 11'd256, 11'd696, 3'b010},
    '{11'd512, 11'd256, 11'd768, 12'd0, 12'd0, 12'd50, 11'd512, 11'd256, 11'd768, 3'b100},
    '{11'd1024, 11'd100, 11'd200, 12'd900, 12'd1, 12'd2, 11'd1024, 11'd100, 11'd200, 3'b001},
    '{11'd255, 11'd511, 11'd767, 12'd1, 12'd2, 12'd3, 11'd0, 11'd256, 11'd512, 3'b100}
  };
  // tags per vector: R3 R4 R5 R5 R1 R2 R2 R1 R3 R4 R3
  localparam string TAGS [NV] = '{"R3", "R4", "R5", "R5", "R1", "R2", "R2", "R1", "R3", "R4", "R3"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample = 1'b0;
  logic [CTRL_W-1:0] va = '0, vb = '0, vc = '0;
  logic signed [CUR_W-1:0] ia = '0, ib = '0, ic = '0;
  logic valid;
  logic [CTRL_W-1:0] sa, sb, sc;
  logic [2:0] clamp;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clamp_offset_sel #(.FRAC_W(FRAC_W), .CUR_W(CUR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample),
    .ctrl_a_i(va), .ctrl_b_i(vb), .ctrl_c_i(vc),
    .cur_a_i(ia), .cur_b_i(ib), .cur_c_i(ic),
    .valid_o(valid), .shift_a_o(sa), .shift_b_o(sb), .shift_c_o(sc),
    .clamp_o(clamp)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    va = v.va; vb = v.vb; vc = v.vc;
    ia = v.ia; ib = v.ib; ic = v.ic;
    sample = 1'b1;
  endtask

  task automatic chk_out(input string req, input vec_t v);
    chk(req, "valid", 32'(valid), 32'd1);
    chk(req, "shift_a", 32'(sa), 32'(v.oa));
    chk(req, "shift_b", 32'(sb), 32'(v.ob));
    chk(req, "shift_c", 32'(sc), 32'(v.oc));
    chk(req, "clamp", 32'(clamp), 32'(v.ck));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "valid", 32'(valid), 32'd0);
    chk("R9", "shift_a", 32'(sa), 32'd0);
    chk("R9", "clamp", 32'(clamp), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      @(negedge clk);
      sample = 1'b0;
      chk("R8", "valid_early", 32'(valid), 32'd0);
      @(negedge clk);
      chk_out(TAGS[k], VECS[k]);
      @(negedge clk);
      chk("R8", "valid_pulse", 32'(valid), 32'd0);
    end

    // R8: inputs change without strobe, outputs hold last result
    va = 11'd700; vb = 11'd50; vc = 11'd999; ia = 12'd1000; ib = 12'd0; ic = 12'd0;
    repeat (3) @(negedge clk);
    chk("R8", "hold_valid", 32'(valid), 32'd0);
    chk("R8", "hold_a", 32'(sa), 32'(VECS[NV-1].oa));
    chk("R8", "hold_c", 32'(sc), 32'(VECS[NV-1].oc));
    chk("R8", "hold_clamp", 32'(clamp), 32'(VECS[NV-1].ck));

    // R8: back-to-back strobes keep order and latency
    drive(VECS[2]);
    @(negedge clk);
    drive(VECS[0]);
    @(negedge clk);
    sample = 1'b0;
    chk_out("R8", VECS[2]);
    @(negedge clk);
    chk_out("R8", VECS[0]);
    @(negedge clk);
    chk("R8", "valid_end", 32'(valid), 32'd0);

    // R9: reset mid-run clears results
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9", "rst_shift_b", 32'(sb), 32'd0);
    chk("R9", "rst_clamp", 32'(clamp), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule